// File: doc/BRIEF.md
# Interleaved Flash Bus Arbiter

Several flash controller units share one flash data bus, and each unit drives its own NAND chip. Foreground units serve host reads. Background units move buffered host writes into flash, and several of them may do so at once on different chips. A unit raises its request only while it has a data transfer to make. It signals done when that transfer phase is over and then gives up the bus while its chip programs or reads internally. The long internal busy time of one chip therefore overlaps the short data transfers of the others.

The arbiter hands the bus to one unit at a time. A foreground request always beats a background request. Inside each class the grants rotate round-robin, starting after the unit served last. A unit whose chip reports busy takes no part in arbitration. A grant is never taken back part way through a transfer.

Top module: `flash_bus_arb`

## Requirements
- R1: While reset is active and on the first cycle after it, `fg_gnt` and `bg_gnt` are all zeros.
- R2: At most one bit is set across `fg_gnt` and `bg_gnt` together in every cycle.
- R3: A grant bit only becomes set in the cycle after that unit's request bit was high.
- R4: When the bus is free (no grant, or the owner asserts done) and any foreground unit is eligible, the next grant goes to a foreground unit, even when background units are also requesting.
- R5: Within a class, the next grant goes to the first eligible unit found by scanning upward from the index after the last unit granted in that class, wrapping at the top. After reset the scan starts at index 0.
- R6: A grant is held unchanged until its owner asserts its done bit. Dropping the owner's request or raising the owner's busy does not remove the grant.
- R7: On the clock edge where the owner's done bit is high, the grant moves to the arbitration winner of that cycle, or to all zeros if no unit is eligible.
- R8: A done bit from a unit that does not hold the grant has no effect on the grant.
- R9: With no eligible request and no grant held, the grant vectors stay all zeros.
- R10: A unit whose busy bit is high is skipped by arbitration and is not newly granted. It becomes eligible again once busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fg_req | input | N_FG | Foreground units: request the bus for a transfer |
| fg_busy | input | N_FG | Foreground units: chip busy internally |
| fg_done | input | N_FG | Foreground units: transfer phase finished |
| fg_gnt | output | N_FG | Foreground units: bus granted (one-hot or zero) |
| bg_req | input | N_BG | Background units: request the bus for a transfer |
| bg_busy | input | N_BG | Background units: chip busy internally |
| bg_done | input | N_BG | Background units: transfer phase finished |
| bg_gnt | output | N_BG | Background units: bus granted (one-hot or zero) |

## Verification
The bench builds the arbiter with two foreground units and three background units. With an odd background count, wrap-around of the rotation is seen at a non-power-of-two boundary. Two foreground units are enough to show foreground requests starving background ones. A directed opening covers mid-transfer hold, stray done bits, busy masking and rotation wrap. After that, a long stretch of random request, busy and done traffic is compared every cycle against a queue-free behavioural model of ownership and rotation pointers.

// File: rtl/flash_bus_arb.sv
module flash_bus_arb #(
  parameter int N_FG = 2,
  parameter int N_BG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FG-1:0] fg_req,
  input  logic [N_FG-1:0] fg_busy,
  input  logic [N_FG-1:0] fg_done,
  output logic [N_FG-1:0] fg_gnt,
  input  logic [N_BG-1:0] bg_req,
  input  logic [N_BG-1:0] bg_busy,
  input  logic [N_BG-1:0] bg_done,
  output logic [N_BG-1:0] bg_gnt
);
  localparam int FW = (N_FG > 1) ? $clog2(N_FG) : 1;
  localparam int BW = (N_BG > 1) ? $clog2(N_BG) : 1;

  logic [FW-1:0] fg_last, fg_pick;
  logic [BW-1:0] bg_last, bg_pick;
  logic          fg_hit, bg_hit;
  logic [N_FG-1:0] fg_next;
  logic [N_BG-1:0] bg_next;

  wire [N_FG-1:0] fg_elig = fg_req & ~fg_busy;
  wire [N_BG-1:0] bg_elig = bg_req & ~bg_busy;

  wire idle    = (fg_gnt == '0) && (bg_gnt == '0);
  wire release_now = |(fg_gnt & fg_done) || |(bg_gnt & bg_done);
  wire bus_free = idle || release_now;

  always_comb begin
    int idx;
    fg_hit  = 1'b0;
    fg_pick = '0;
    for (int k = 1; k <= N_FG; k++) begin
      idx = (int'(fg_last) + k) % N_FG;
      if (!fg_hit && fg_elig[idx]) begin
        fg_hit  = 1'b1;
        fg_pick = idx[FW-1:0];
      end
    end
    fg_next = '0;
    fg_next[fg_pick] = 1'b1;
  end

  always_comb begin
    int idx;
    bg_hit  = 1'b0;
    bg_pick = '0;
    for (int k = 1; k <= N_BG; k++) begin
      idx = (int'(bg_last) + k) % N_BG;
      if (!bg_hit && bg_elig[idx]) begin
        bg_hit  = 1'b1;
        bg_pick = idx[BW-1:0];
      end
    end
    bg_next = '0;
    bg_next[bg_pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fg_gnt  <= '0;
      bg_gnt  <= '0;
      fg_last <= FW'(N_FG - 1);
      bg_last <= BW'(N_BG - 1);
    end else if (bus_free) begin
      if (fg_hit) begin
        fg_gnt  <= fg_next;
        bg_gnt  <= '0;
        fg_last <= fg_pick;
      end else if (bg_hit) begin
        fg_gnt  <= '0;
        bg_gnt  <= bg_next;
        bg_last <= bg_pick;
      end else begin
        fg_gnt <= '0;
        bg_gnt <= '0;
      end
    end
  end
endmodule

// File: rtl/flash_bus_arb_chk.sv
module flash_bus_arb_chk #(
  parameter int N_FG = 2,
  parameter int N_BG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_FG-1:0] fg_req,
  input logic [N_FG-1:0] fg_busy,
  input logic [N_FG-1:0] fg_done,
  input logic [N_FG-1:0] fg_gnt,
  input logic [N_BG-1:0] bg_req,
  input logic [N_BG-1:0] bg_busy,
  input logic [N_BG-1:0] bg_done,
  input logic [N_BG-1:0] bg_gnt
);
  localparam int NU = N_FG + N_BG;
  wire [NU-1:0] g = {bg_gnt, fg_gnt};
  wire [NU-1:0] r = {bg_req, fg_req};
  wire [NU-1:0] b = {bg_busy, fg_busy};
  wire [NU-1:0] d = {bg_done, fg_done};
  wire any_fg = |(fg_req & ~fg_busy);
  wire any_el = any_fg || |(bg_req & ~bg_busy);
  wire freed  = (g == '0) || ((g & d) != '0);

  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g));
  p_grant_had_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && g != $past(g)) |-> (($past(r) & g) != '0));
  p_grant_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && g != $past(g)) |-> (($past(~b) & g) != '0));
  p_fg_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (freed && any_fg) |=> (fg_gnt != '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (g != '0 && (g & d) == '0) |=> (g == $past(g)));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((g & d) != '0 && !any_el) |=> (g == '0));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (g == '0 && !any_el) |=> (g == '0));
endmodule

bind flash_bus_arb flash_bus_arb_chk #(.N_FG(N_FG), .N_BG(N_BG)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fg_req(fg_req), .fg_busy(fg_busy), .fg_done(fg_done), .fg_gnt(fg_gnt),
  .bg_req(bg_req), .bg_busy(bg_busy), .bg_done(bg_done), .bg_gnt(bg_gnt)
);

// File: tb/flash_bus_arb_bench.sv
`timescale 1ns/1ps
module flash_bus_arb_bench;
  localparam int NF = 2;
  localparam int NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] fg_req = '0, fg_busy = '0, fg_done = '0, fg_gnt;
  logic [NB-1:0] bg_req = '0, bg_busy = '0, bg_done = '0, bg_gnt;

  int checks = 0;
  int errors = 0;

  int own_c = -1;
  int own_i = 0;
  int lf = NF - 1;
  int lb = NB - 1;

  always #2.5 clk = ~clk;

  flash_bus_arb #(.N_FG(NF), .N_BG(NB)) u_flash_bus_arb (
    .clk(clk), .rst_n(rst_n),
    .fg_req(fg_req), .fg_busy(fg_busy), .fg_done(fg_done), .fg_gnt(fg_gnt),
    .bg_req(bg_req), .bg_busy(bg_busy), .bg_done(bg_done), .bg_gnt(bg_gnt)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit free, found;
    if (!rst_n) begin
      own_c = -1; own_i = 0; lf = NF - 1; lb = NB - 1;
      return;
    end
    free = (own_c < 0) || (own_c == 0 && fg_done[own_i]) || (own_c == 1 && bg_done[own_i]);
    if (!free) return;
    found = 0;
    for (int k = 1; k <= NF; k++) begin
      int i = (lf + k) % NF;
      if (!found && fg_req[i] && !fg_busy[i]) begin
        found = 1; own_c = 0; own_i = i; lf = i;
      end
    end
    for (int k = 1; k <= NB; k++) begin
      int i = (lb + k) % NB;
      if (!found && bg_req[i] && !bg_busy[i]) begin
        found = 1; own_c = 1; own_i = i; lb = i;
      end
    end
    if (!found) own_c = -1;
  endtask

  function automatic logic [31:0] exp_fg();
    logic [31:0] v = '0;
    if (own_c == 0) v[own_i] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_bg();
    logic [31:0] v = '0;
    if (own_c == 1) v[own_i] = 1'b1;
    return v;
  endfunction

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(32'(fg_gnt), exp_fg(), "R5 model fg_gnt");
    check(32'(bg_gnt), exp_bg(), "R5 model bg_gnt");
    check(32'($countones({bg_gnt, fg_gnt}) <= 1), 32'd1, "R2 single owner");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc();
    check(32'({bg_gnt, fg_gnt}), 32'd0, "R1 grants in reset");
    @(negedge clk) rst_n = 1'b1;
    cyc();
    check(32'({bg_gnt, fg_gnt}), 32'd0, "R1 after reset");
    cyc();
    check(32'({bg_gnt, fg_gnt}), 32'd0, "R9 idle stays zero");

    fg_req = 2'b01; bg_req = 3'b001;
    cyc();
    check(32'(fg_gnt), 32'd1, "R4 foreground wins");
    check(32'(bg_gnt), 32'd0, "R4 background waits");

    fg_req = 2'b00; bg_done = 3'b001;
    cyc();
    check(32'(fg_gnt), 32'd1, "R8 stray done ignored");
    bg_done = '0; fg_busy = 2'b01;
    cyc();
    check(32'(fg_gnt), 32'd1, "R6 held while busy and no req");

    fg_busy = '0; fg_req = 2'b10; fg_done = 2'b01;
    cyc();
    check(32'(fg_gnt), 32'd2, "R7 moves on done");
    fg_done = '0;
    cyc();
    check(32'(fg_gnt), 32'd2, "R6 held without done");

    fg_req = '0; fg_done = 2'b10; bg_req = 3'b111; bg_busy = 3'b001;
    cyc();
    check(32'(bg_gnt), 32'd2, "R10 busy unit skipped");
    fg_done = '0; bg_busy = '0; bg_done = 3'b010;
    cyc();
    check(32'(bg_gnt), 32'd4, "R5 rotate to next");
    bg_done = 3'b100;
    cyc();
    check(32'(bg_gnt), 32'd1, "R10 unit eligible after busy drops, R5 wrap");
    bg_req = '0; bg_done = 3'b001;
    cyc();
    check(32'({bg_gnt, fg_gnt}), 32'd0, "R7 release to zero");
    bg_done = '0;
    cyc();
    check(32'({bg_gnt, fg_gnt}), 32'd0, "R9 stays zero");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] t;
      t = $urandom();
      fg_req  = t[NF-1:0] & {NF{t[20] & t[21]}};
      fg_busy = t[NF+1:2] & {NF{t[22]}};
      bg_req  = t[8 +: NB];
      bg_busy = t[12 +: NB] & {NB{t[23]}};
      fg_done = t[16 +: NF] & {NF{t[24] & t[25]}};
      bg_done = t[28 +: NB] & {NB{t[26]}};
      if (n % 500 == 250) begin
        rst_n = 1'b0;
        cyc();
        check(32'({bg_gnt, fg_gnt}), 32'd0, "R1 mid-run reset");
        rst_n = 1'b1;
      end
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule